// File: doc/BRIEF.md
# Five-Instruction Single-Cycle Processor Core

This block is a compact 32-bit processor core that completes one instruction on every rising clock edge. Each cycle it fetches a word from its instruction store at the program counter and decodes it. It reads up to two source registers, computes either an arithmetic result or an effective address, and commits the result in the same cycle. The result goes either into the register file or into a small word-organised data store. Five operations are understood: register add, register subtract, add of a signed 16-bit constant, word load and word store. Every other encoding passes through as a no-op.

Programs are placed into the instruction store through a write-only preload port, which works whether or not the core is held in reset. A combinational debug port returns any register's current value, so results can be observed without adding instructions. Typical use is to hold reset low, preload the program, release reset and let the program counter step through the store. The counter wraps when it passes the end of the store.

Top module: `scpu_core`

## Requirements
- R1: While `rst_n` is low, the program counter reads 0, and every register and every data-store word is cleared to 0. Instruction-store contents are kept.
- R2: After reset is released, each rising clock edge advances `pc_out` by 4. The instruction executed is the store entry selected by `pc_out[IM_AW+1:2]`, so fetch wraps around the store.
- R3: Register 0 always reads as 0, and any write aimed at it has no effect.
- R4: Opcode bits [31:26] = 0 with function bits [5:0] = 32 writes rs + rt into register rd, wrapping modulo 2^32 with no trap.
- R5: Opcode 0 with function 34 writes rs − rt into rd, wrapping modulo 2^32.
- R6: Opcode 8 writes rs + sign-extended immediate[15:0] into register rt.
- R7: Opcode 35 loads into rt the data-store word indexed by bits [DM_AW+1:2] of rs + sign-extended offset. Negative offsets select words below the base.
- R8: Opcode 43 writes register rt into the data-store word at the same computed index on the clock edge. A later load of that word returns the stored value. A store changes no register.
- R9: Any other opcode, and opcode 0 with any function other than 32 or 34, changes neither the registers nor the data store.
- R10: Fields decode as rs = bits [25:21], rt = bits [20:16] and rd = bits [15:11]. The register-form destination is rd, and the immediate-form destination is rt.
- R11: With `load_we` high, `load_data` is written into instruction-store entry `load_addr` on the rising edge.
- R12: `dbg_data` combinationally shows the register selected by `dbg_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_we | input | 1 | Instruction-store preload write enable |
| load_addr | input | IM_AW | Instruction-store entry to preload |
| load_data | input | 32 | Instruction word to preload |
| dbg_addr | input | 5 | Register selected for the debug port |
| dbg_data | output | 32 | Value of the selected register |
| pc_out | output | 32 | Current program counter |

## Verification
A wrong program counter shows on `pc_out` at the very next edge, because it must step by exactly 4 from the previous value. A decode or datapath fault leaves a corrupted register, and that register is visible at once on `dbg_data`. A data-store fault stays hidden until a later load reads the affected word and copies it into a register, so random programs mix stores with loads at negative and positive offsets from one base register. Directed sequences cover arithmetic wrap, writes to register 0, aliasing addresses and undecoded words.

// File: rtl/scpu_pkg.sv
`timescale 1ns/1ps
package scpu_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RA_W   = $clog2(NREG);

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_ADDI  = 6'd8;
    localparam logic [5:0] OPC_LW    = 6'd35;
    localparam logic [5:0] OPC_SW    = 6'd43;
    localparam logic [5:0] FN_ADD    = 6'd32;
    localparam logic [5:0] FN_SUB    = 6'd34;

    typedef struct packed {
        logic            rf_we;
        logic            dm_we;
        logic            b_imm;
        logic            alu_sub;
        logic            wb_mem;
        logic [RA_W-1:0] ra;
        logic [RA_W-1:0] rb;
        logic [RA_W-1:0] rw;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction
endpackage

// File: rtl/scpu_regfile.sv
`timescale 1ns/1ps
module scpu_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b,
    input  logic [AW-1:0] raddr_d,
    output logic [W-1:0]  rdata_d
);
    logic [W-1:0] regs [NREG];

    // entry 0 is a constant zero; the rest are real storage
    assign regs[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
    assign rdata_d = regs[raddr_d];
endmodule

// File: rtl/scpu_decoder.sv
`timescale 1ns/1ps
module scpu_decoder
    import scpu_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl
);
    logic [5:0] opc;
    logic [5:0] fn;
    logic [4:0] unused_shamt;

    assign opc          = instr[31:26];
    assign fn           = instr[5:0];
    assign unused_shamt = instr[10:6];

    always_comb begin
        ctrl         = '0;
        ctrl.ra      = instr[25:21];
        ctrl.rb      = instr[20:16];
        ctrl.rw      = instr[20:16];
        unique case (opc)
            OPC_RTYPE: begin
                ctrl.rw = instr[15:11];
                if (fn == FN_ADD) begin
                    ctrl.rf_we = 1'b1;
                end else if (fn == FN_SUB) begin
                    ctrl.rf_we   = 1'b1;
                    ctrl.alu_sub = 1'b1;
                end
            end
            OPC_ADDI: begin
                ctrl.rf_we = 1'b1;
                ctrl.b_imm = 1'b1;
            end
            OPC_LW: begin
                ctrl.rf_we  = 1'b1;
                ctrl.b_imm  = 1'b1;
                ctrl.wb_mem = 1'b1;
            end
            OPC_SW: begin
                ctrl.dm_we = 1'b1;
                ctrl.b_imm = 1'b1;
            end
            default: begin
                ctrl.rf_we = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/scpu_alu.sv
`timescale 1ns/1ps
module scpu_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    always_comb begin
        if (sub) y = a - b;
        else     y = a + b;
    end
endmodule

// File: rtl/scpu_wordmem.sv
`timescale 1ns/1ps
module scpu_wordmem #(
    parameter int WORDS    = 64,
    parameter int W        = 32,
    parameter bit RESET_EN = 1'b1,
    localparam int IW      = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [WORDS];

    if (RESET_EN) begin : g_rst
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < WORDS; i++) mem[i] <= '0;
            end else if (we) begin
                mem[widx] <= wdata;
            end
        end
    end else begin : g_norst
        logic unused_rst;
        assign unused_rst = rst_n;
        always_ff @(posedge clk) begin
            if (we) mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/scpu_core.sv
`timescale 1ns/1ps
module scpu_core
    import scpu_pkg::*;
#(
    parameter int IM_WORDS = 64,
    parameter int DM_WORDS = 64,
    localparam int IM_AW   = $clog2(IM_WORDS),
    localparam int DM_AW   = $clog2(DM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_we,
    input  logic [IM_AW-1:0] load_addr,
    input  logic [31:0]      load_data,
    input  logic [4:0]       dbg_addr,
    output logic [31:0]      dbg_data,
    output logic [31:0]      pc_out
);
    logic [31:0] pc;
    logic [31:0] instr;
    ctrl_t       ctrl;
    logic [31:0] rs_data;
    logic [31:0] rt_data;
    logic [31:0] imm_ext;
    logic [31:0] alu_b;
    logic [31:0] alu_y;
    logic [31:0] dm_rdata;
    logic [31:0] rf_wdata;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic        dm_we;
    logic        unused_bits;

    // program counter: one word per cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc + 32'd4;
    end
    assign pc_out = pc;

    scpu_wordmem #(.WORDS(IM_WORDS), .W(32), .RESET_EN(1'b0)) u_imem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (load_we),
        .widx  (load_addr),
        .wdata (load_data),
        .ridx  (pc[IM_AW+1:2]),
        .rdata (instr)
    );

    scpu_decoder u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    assign rf_we    = ctrl.rf_we;
    assign rf_waddr = ctrl.rw;
    assign dm_we    = ctrl.dm_we;

    scpu_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (ctrl.ra),
        .rdata_a (rs_data),
        .raddr_b (ctrl.rb),
        .rdata_b (rt_data),
        .raddr_d (dbg_addr),
        .rdata_d (dbg_data)
    );

    assign imm_ext = sext16(instr[15:0]);
    assign alu_b   = ctrl.b_imm ? imm_ext : rt_data;

    scpu_alu #(.W(XLEN)) u_alu (
        .a   (rs_data),
        .b   (alu_b),
        .sub (ctrl.alu_sub),
        .y   (alu_y)
    );

    scpu_wordmem #(.WORDS(DM_WORDS), .W(32), .RESET_EN(1'b1)) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dm_we),
        .widx  (alu_y[DM_AW+1:2]),
        .wdata (rt_data),
        .ridx  (alu_y[DM_AW+1:2]),
        .rdata (dm_rdata)
    );

    assign rf_wdata = ctrl.wb_mem ? dm_rdata : alu_y;

    assign unused_bits = ^{pc[31:IM_AW+2], pc[1:0], alu_y[31:DM_AW+2], alu_y[1:0]};
endmodule

// File: rtl/scpu_core_chk.sv
`timescale 1ns/1ps
module scpu_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc_out,
    input logic [31:0] instr,
    input logic        rf_we,
    input logic [4:0]  rf_waddr,
    input logic [31:0] rf_wdata,
    input logic        dm_we,
    input logic [31:0] rs_data,
    input logic [31:0] rt_data,
    input logic [4:0]  dbg_addr,
    input logic [31:0] dbg_data
);
    logic started;
    logic is_add, is_sub, is_addi, is_lw, is_sw, known;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    assign is_add  = (instr[31:26] == 6'd0) && (instr[5:0] == 6'd32);
    assign is_sub  = (instr[31:26] == 6'd0) && (instr[5:0] == 6'd34);
    assign is_addi = (instr[31:26] == 6'd8);
    assign is_lw   = (instr[31:26] == 6'd35);
    assign is_sw   = (instr[31:26] == 6'd43);
    assign known   = is_add || is_sub || is_addi || is_lw || is_sw;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> pc_out == $past(pc_out) + 32'd4); // R2

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_addr == 5'd0) |-> (dbg_data == 32'd0)); // R3

    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        is_add |-> (rf_we && rf_waddr == instr[15:11] && rf_wdata == rs_data + rt_data)); // R4

    AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        is_sub |-> (rf_we && rf_waddr == instr[15:11] && rf_wdata == rs_data - rt_data)); // R5

    AST_LOAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        is_lw |-> (rf_we && !dm_we && rf_waddr == instr[20:16])); // R7

    AST_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        is_sw |-> (dm_we && !rf_we)); // R8

    AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> (!rf_we && !dm_we)); // R9
endmodule

bind scpu_core scpu_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_out   (pc_out),
    .instr    (instr),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr),
    .rf_wdata (rf_wdata),
    .dm_we    (dm_we),
    .rs_data  (rs_data),
    .rt_data  (rt_data),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
);

// File: tb/scpu_core_test.sv
`timescale 1ns/1ps
module scpu_core_test;
    localparam int IM_WORDS = 64;
    localparam int DM_WORDS = 64;
    localparam int IM_AW    = $clog2(IM_WORDS);
    localparam int DM_AW    = $clog2(DM_WORDS);
    localparam int RAND_LEN = 48;
    localparam int RAND_RUN = 56;

    logic             clk = 1'b0;
    bit               clk_en = 1'b1;
    logic             rst_n = 1'b0;
    logic             load_we = 1'b0;
    logic [IM_AW-1:0] load_addr = '0;
    logic [31:0]      load_data = '0;
    logic [4:0]       dbg_addr = '0;
    logic [31:0]      dbg_data;
    logic [31:0]      pc_out;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    logic [31:0] prog [IM_WORDS];
    logic [31:0] m_rf [32];
    logic [31:0] m_dm [DM_WORDS];

    always #2 if (clk_en) clk = ~clk;   // 250 MHz

    scpu_core #(.IM_WORDS(IM_WORDS), .DM_WORDS(DM_WORDS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data),
        .dbg_addr  (dbg_addr),
        .dbg_data  (dbg_data),
        .pc_out    (pc_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] gen_instr();
        int sel = int'($urandom % 10);
        logic [4:0] rs = 5'($urandom % 32);
        logic [4:0] rt = 5'($urandom % 32);
        logic [4:0] d  = 5'($urandom % 31);
        int k = int'($urandom % 64) - 32;
        logic [15:0] off = 16'(k * 4);
        case (sel)
            0, 1:    return enc_r(rs, rt, d, 6'd32);
            2:       return enc_r(rs, rt, d, 6'd34);
            3, 4:    return enc_i(6'd8, rs, d, 16'($urandom));
            5, 6:    return enc_i(6'd35, 5'd31, d, off);
            7, 8:    return enc_i(6'd43, 5'd31, rt, off);
            default: begin
                if ($urandom % 2 == 0) return enc_r(rs, rt, d, 6'($urandom % 32));
                return enc_i(6'd13, rs, d, 16'($urandom));
            end
        endcase
    endfunction

    // bench reference, written from R3-R10
    task automatic model_step(input logic [31:0] ins);
        logic [5:0]  op = ins[31:26];
        logic [4:0]  rs = ins[25:21];
        logic [4:0]  rt = ins[20:16];
        logic [4:0]  rd = ins[15:11];
        logic [31:0] se = {{16{ins[15]}}, ins[15:0]};
        logic [31:0] ea = m_rf[rs] + se;
        logic [DM_AW-1:0] wi = ea[DM_AW+1:2];
        if (op == 6'd0 && ins[5:0] == 6'd32 && rd != 0) m_rf[rd] = m_rf[rs] + m_rf[rt];
        else if (op == 6'd0 && ins[5:0] == 6'd34 && rd != 0) m_rf[rd] = m_rf[rs] - m_rf[rt];
        else if (op == 6'd8 && rt != 0) m_rf[rt] = ea;
        else if (op == 6'd35 && rt != 0) m_rf[rt] = m_dm[wi];
        else if (op == 6'd43) m_dm[wi] = m_rf[rt];
    endtask

    // R11: program preload through the port while reset is held
    task automatic load_and_start();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < IM_WORDS; i++) begin
            load_we   = 1'b1;
            load_addr = IM_AW'(i);
            load_data = prog[i];
            @(negedge clk);
        end
        load_we = 1'b0;
        chk("R1 pc in reset", pc_out, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic run_stop(input int n);
        repeat (n) @(negedge clk);
        clk_en = 1'b0;
        chk("R2 pc after run", pc_out, 32'(4 * n));
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] v);
        dbg_addr = a;
        #1;
        v = dbg_data;
    endtask

    task automatic expect_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd_reg(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);

        // ---------------- directed program ----------------
        for (int i = 0; i < IM_WORDS; i++) prog[i] = 32'd0;
        prog[0]  = enc_i(6'd8, 5'd0, 5'd31, 16'd128);
        prog[1]  = enc_i(6'd8, 5'd0, 5'd1, 16'hFFFF);
        prog[2]  = enc_i(6'd8, 5'd0, 5'd2, 16'd1);
        prog[3]  = enc_r(5'd1, 5'd2, 5'd3, 6'd32);
        prog[4]  = enc_r(5'd0, 5'd2, 5'd4, 6'd34);
        prog[5]  = enc_i(6'd8, 5'd0, 5'd0, 16'd5);
        prog[6]  = enc_i(6'd43, 5'd31, 5'd1, 16'hFFF8);
        prog[7]  = enc_i(6'd35, 5'd31, 5'd5, 16'hFFF8);
        prog[8]  = enc_i(6'd35, 5'd0, 5'd6, 16'd4);
        prog[9]  = enc_i(6'd42, 5'd0, 5'd1, 16'd8);
        prog[10] = enc_r(5'd1, 5'd2, 5'd8, 6'd33);
        prog[11] = enc_i(6'd35, 5'd0, 5'd10, 16'd8);
        prog[12] = enc_i(6'd35, 5'd0, 5'd9, 16'd120);
        prog[13] = enc_i(6'd8, 5'd0, 5'd11, 16'h7FFF);
        prog[14] = enc_r(5'd11, 5'd11, 5'd12, 6'd32);
        prog[15] = enc_r(5'd2, 5'd1, 5'd13, 6'd34);

        load_and_start();
        clk_en = 1'b0;
        expect_reg("R1 reg cleared", 5'd1, 32'd0);
        clk_en = 1'b1;
        run_stop(20);
        expect_reg("R3 r0 write discarded", 5'd0, 32'd0);
        expect_reg("R6 addi negative imm", 5'd1, 32'hFFFF_FFFF);
        expect_reg("R6 addi positive imm", 5'd11, 32'h0000_7FFF);
        expect_reg("R4 add wraps", 5'd3, 32'd0);
        expect_reg("R4 add rd field", 5'd12, 32'h0000_FFFE);
        expect_reg("R5 sub wraps", 5'd4, 32'hFFFF_FFFF);
        expect_reg("R5 sub order", 5'd13, 32'd2);
        expect_reg("R7 R8 negative offset", 5'd5, 32'hFFFF_FFFF);
        expect_reg("R1 data store cleared", 5'd6, 32'd0);
        expect_reg("R9 bad funct no write", 5'd8, 32'd0);
        expect_reg("R9 bad opcode no store", 5'd10, 32'd0);
        expect_reg("R7 aliased address", 5'd9, 32'hFFFF_FFFF);
        expect_reg("R12 debug read base", 5'd31, 32'd128);
        clk_en = 1'b1;

        // ---------------- random programs ----------------
        for (int round = 0; round < 4; round++) begin
            for (int i = 0; i < IM_WORDS; i++) prog[i] = 32'd0;
            prog[0] = enc_i(6'd8, 5'd0, 5'd31, 16'd128);
            for (int i = 1; i < RAND_LEN; i++) prog[i] = gen_instr();
            for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
            for (int i = 0; i < DM_WORDS; i++) m_dm[i] = 32'd0;
            for (int i = 0; i < RAND_RUN; i++) model_step(prog[i]);
            load_and_start();
            run_stop(RAND_RUN);
            for (int r = 0; r < 32; r++) begin
                expect_reg("R10 R4 R5 R6 R7 R8 R9 random state", 5'(r), m_rf[r]);
            end
            clk_en = 1'b1;
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule